// File: doc/BRIEF.md
# Open-Drain Parallel Port with Access Strobe

This block is an 8-bit general-purpose I/O port for a peripheral controller on an 8-bit microprocessor bus. Software chooses the direction of each pin through a direction register and sets the output levels through a data register. An output pin is never driven high. It is either pulled low or released, and an external pull-up gives the high level. The block therefore brings out one pull-low enable per pin and leaves the pad buffer to the surrounding chip.

Each clock cycle is one bus cycle. The rising edge of `clk` marks the end of the phase-2 half of that cycle, which is the point where the bus settles and the registers capture. Whenever the CPU reads or writes the port data register, an active-low access strobe is sent to the attached device. The CPU carries out a store as a read of the target address followed by the write in the next cycle. The strobe merges those two accesses into one low pulse two cycles wide, so the device sees a single event.

Top module: `pport`

## Requirements
- R1: After reset the data register and the direction register are both 0, every pull-low enable is 0 and the access strobe is high.
- R2: A bus write (chip select low, `rdWr` = 0) to address 1 loads the direction register at the capturing clock edge. Reading address 1 returns the direction register. A direction bit of 1 makes the pin an output.
- R3: `pinDrvLow[i]` is 1 only when direction bit i is 1 and data bit i is 0. Otherwise the pin is released.
- R4: Reading address 0 returns the latched data bit for output pins and the live `pinIn` level for input pins.
- R5: A single read of address 0 in bus cycle n drives `accessStrbN` low for exactly cycle n+1.
- R6: A read of address 0 followed at once by a write of address 0 gives one continuous low strobe lasting two cycles, with no high cycle between the two.
- R7: A write of address 0 on its own also gives a one-cycle low strobe, and it loads the data register.
- R8: An access with chip select high, or any access to the direction register, gives no strobe. A write with chip select high changes no register.
- R9: The strobe returns high in the first cycle after a cycle with no access to the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus cycle clock; the rising edge ends phase 2 |
| rstN | input | 1 | Asynchronous active-low reset |
| chipSelN | input | 1 | Active-low chip select |
| regAddr | input | 4 | Register address: 0 selects data, 1 selects direction |
| rdWr | input | 1 | 1 = read, 0 = write |
| wrData | input | 8 | Write data from the CPU |
| rdData | output | 8 | Read data to the CPU; 0 when no read is selected |
| pinIn | input | 8 | Sensed pin levels |
| pinDrvLow | output | 8 | Per-pin pull-low enable |
| accessStrbN | output | 1 | Active-low data-register access strobe |

## Verification
Two functions share a cycle in this block: the strobe left by the previous access, and the register load or read-back of the current access. The sharpest case is a dummy read followed directly by a store to the data register. In the second cycle of that pair, the strobe must stay low from the read while the write captures new data and changes the pull-low enables. The scoreboard expects the strobe level in every cycle, so any high gap inside the pair is caught. At the same time it checks the read value and the pin enables from a register model kept in the bench.

// File: rtl/pport_pkg.sv
package pport_pkg;
  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic portAccess;
  } pportCtl_t;
endpackage

// File: rtl/pport_ctrl.sv
module pport_ctrl
  import pport_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdWr,
  output pportCtl_t         ctl,
  output logic              accessStrbN
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

  logic hitData, hitDir, strbQ;

  assign hitData = !chipSelN && (regAddr == DATA_A);
  assign hitDir  = !chipSelN && (regAddr == DIR_A);

  always_comb begin
    ctl.portAccess = hitData;
    ctl.wrData     = hitData && !rdWr;
    ctl.wrDir      = hitDir && !rdWr;
  end

  // Registered strobe: consecutive accesses keep it low without a gap.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) strbQ <= 1'b1;
    else       strbQ <= !ctl.portAccess;
  end
  assign accessStrbN = strbQ;

  a_r5_strobe_after_access: assert property (@(posedge clk) disable iff (!rstN)
    (!chipSelN && regAddr == DATA_A) |=> !accessStrbN);
  a_r9_strobe_release: assert property (@(posedge clk) disable iff (!rstN)
    !(!chipSelN && regAddr == DATA_A) |=> accessStrbN);
  a_r8_no_strobe_deselected: assert property (@(posedge clk) disable iff (!rstN)
    chipSelN |=> accessStrbN);
endmodule

// File: rtl/pport_dp.sv
module pport_dp
  import pport_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  pportCtl_t         ctl,
  input  logic              chipSelN,
  input  logic              rdWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  wrData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  rdData,
  output logic [WIDTH-1:0]  pinDrvLow
);
  localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_OFS);
  localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);

  logic [WIDTH-1:0] dataReg, dirReg, portView;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      dirReg  <= '0;
    end else begin
      if (ctl.wrData) dataReg <= wrData;
      if (ctl.wrDir)  dirReg  <= wrData;
    end
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    assign portView[b]  = dirReg[b] ? dataReg[b] : pinIn[b];
    assign pinDrvLow[b] = dirReg[b] & ~dataReg[b];
  end

  always_comb begin
    rdData = '0;
    if (!chipSelN && rdWr) begin
      if (regAddr == DATA_A)     rdData = portView;
      else if (regAddr == DIR_A) rdData = dirReg;
    end
  end

  a_r3_release_inputs: assert property (@(posedge clk) disable iff (!rstN)
    (pinDrvLow & ~dirReg) == '0);
  a_r8_data_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrData |=> $stable(dataReg));
  a_r2_dir_hold: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.wrDir |=> $stable(dirReg));
  a_r2_dir_load: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wrDir |=> dirReg == $past(wrData));
endmodule

// File: rtl/pport.sv
module pport
  import pport_pkg::*;
#(
  parameter int WIDTH    = 8,
  parameter int ADDR_W   = 4,
  parameter int DATA_OFS = 0,
  parameter int DIR_OFS  = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              chipSelN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              rdWr,
  input  logic [WIDTH-1:0]  wrData,
  output logic [WIDTH-1:0]  rdData,
  input  logic [WIDTH-1:0]  pinIn,
  output logic [WIDTH-1:0]  pinDrvLow,
  output logic              accessStrbN
);
  pportCtl_t ctl;

  pport_ctrl #(.ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_ctrl (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .regAddr(regAddr),
    .rdWr(rdWr), .ctl(ctl), .accessStrbN(accessStrbN)
  );

  pport_dp #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .DATA_OFS(DATA_OFS), .DIR_OFS(DIR_OFS)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .chipSelN(chipSelN), .rdWr(rdWr),
    .regAddr(regAddr), .wrData(wrData), .pinIn(pinIn),
    .rdData(rdData), .pinDrvLow(pinDrvLow)
  );
endmodule

// File: tb/pport_bench.sv
module pport_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       chipSelN = 1'b1;
  logic [3:0] regAddr = '0;
  logic       rdWr = 1'b1;
  logic [7:0] wrData = '0;
  logic [7:0] pinIn = '0;
  logic [7:0] rdData, pinDrvLow;
  logic       accessStrbN;

  always #5 clk = ~clk;

  pport u_pport (
    .clk(clk), .rstN(rstN), .chipSelN(chipSelN), .regAddr(regAddr), .rdWr(rdWr),
    .wrData(wrData), .rdData(rdData), .pinIn(pinIn), .pinDrvLow(pinDrvLow),
    .accessStrbN(accessStrbN)
  );

  typedef struct {
    int         due;
    int         kind;   // 0 rdData, 1 pinDrvLow, 2 strobe
    logic [7:0] exp;
    string      req;
  } item_t;

  item_t sbq[$];
  int cycCnt = 0;
  int nChecks = 0;
  int nFails = 0;
  logic [7:0] mData = '0, mDir = '0;
  bit done = 0;

  always @(posedge clk) cycCnt <= cycCnt + 1;

  // Monitor: compares every due expectation mid-cycle.
  always @(negedge clk) begin
    while (sbq.size() > 0 && sbq[0].due <= cycCnt) begin
      item_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.kind)
        0:       act = rdData;
        1:       act = pinDrvLow;
        default: act = {7'd0, accessStrbN};
      endcase
      nChecks++;
      if (act !== it.exp) begin
        nFails++;
        $display("FAIL %s kind=%0d cycle=%0d actual=%h expected=%h",
                 it.req, it.kind, cycCnt, act, it.exp);
      end
    end
  end

  task automatic busCyc(input logic cs, input logic [3:0] a, input logic rw,
                        input logic [7:0] wd, input logic [7:0] pins,
                        input string dTag, input string sTag);
    item_t it;
    logic [7:0] expRd;
    logic acc;
    @(posedge clk);
    #1;
    chipSelN = cs; regAddr = a; rdWr = rw; wrData = wd; pinIn = pins;
    expRd = 8'h00;
    if (!cs && rw) begin
      if (a == 4'd0)      expRd = (mDir & mData) | (~mDir & pins);
      else if (a == 4'd1) expRd = mDir;
    end
    it.due = cycCnt; it.kind = 0; it.exp = expRd; it.req = dTag; sbq.push_back(it);
    it.kind = 1; it.exp = mDir & ~mData; it.req = "R3"; sbq.push_back(it);
    acc = !cs && (a == 4'd0);
    it.due = cycCnt + 1; it.kind = 2; it.exp = {7'd0, !acc}; it.req = sTag; sbq.push_back(it);
    if (!cs && !rw && a == 4'd0) mData = wd;
    if (!cs && !rw && a == 4'd1) mDir = wd;
  endtask

  task automatic idle(input string sTag);
    busCyc(1'b1, 4'd0, 1'b1, 8'h00, pinIn, "R8", sTag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    idle("R1");                                           // strobe high after reset
    busCyc(1'b0, 4'd1, 1'b1, 8'h00, 8'h00, "R1", "R8");   // direction reads 0
    busCyc(1'b0, 4'd0, 1'b1, 8'h00, 8'hA5, "R4", "R5");   // single read, all inputs
    idle("R9");
    busCyc(1'b0, 4'd1, 1'b0, 8'hF0, 8'hA5, "R2", "R8");   // dir write: no strobe
    busCyc(1'b0, 4'd1, 1'b1, 8'h00, 8'hA5, "R2", "R8");
    busCyc(1'b0, 4'd0, 1'b0, 8'h30, 8'hA5, "R7", "R7");   // lone write
    idle("R9");
    busCyc(1'b0, 4'd0, 1'b1, 8'h00, 8'h0F, "R4", "R6");   // dummy read ...
    busCyc(1'b0, 4'd0, 1'b0, 8'h55, 8'h0F, "R7", "R6");   // ... then write
    idle("R6");
    busCyc(1'b1, 4'd1, 1'b0, 8'hFF, 8'h0F, "R8", "R8");   // deselected write ignored
    busCyc(1'b0, 4'd1, 1'b1, 8'h00, 8'h0F, "R8", "R8");
    busCyc(1'b1, 4'd0, 1'b0, 8'h00, 8'h0F, "R8", "R8");
    busCyc(1'b0, 4'd0, 1'b1, 8'h00, 8'h0A, "R4", "R5");   // live input bits
    idle("R9");
    busCyc(1'b0, 4'd1, 1'b0, 8'hFF, 8'h0A, "R2", "R8");
    busCyc(1'b0, 4'd0, 1'b0, 8'h00, 8'h0A, "R3", "R7");   // all pulled low
    busCyc(1'b0, 4'd0, 1'b0, 8'hFF, 8'h0A, "R3", "R7");   // all released
    busCyc(1'b0, 4'd0, 1'b1, 8'h00, 8'h00, "R4", "R6");
    idle("R9");
    busCyc(1'b0, 4'd1, 1'b0, 8'h00, 8'h3C, "R2", "R8");
    busCyc(1'b0, 4'd0, 1'b1, 8'h00, 8'h3C, "R4", "R5");
    idle("R9");
    idle("R9");
    @(posedge clk);
    @(negedge clk);
    #1;
    done = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule